// File: doc/BRIEF.md
# Per-Timeslot Output Source Selector

This block decides the byte that each output timeslot of a time-division switch carries. On every slot strobe it presents the current output stream and channel as an address to the connection store. It then decodes the two mode bits of the word it reads back. From that word it either fetches a switched byte from the data store, passes on the word's low byte as a fixed message, or emits the next byte of a pseudo-random test sequence.

The connection store and the data store are external and are read combinationally. The data store holds two banks: the bank that incoming data is filling in the current frame, and the bank filled in the previous frame. Variable-delay switching reads the first bank, which gives the lowest latency. Constant-delay switching reads the second bank, so the delay through the switch is the same for every channel. The chosen byte is registered and appears one clock after the slot strobe.

Top module: `slot_src_sel`

## Requirements
- R1: Mode 00 (connection word bits [SW+CW+1:SW+CW]) selects variable delay. The output byte is the data-store byte at address {wr_bank, source stream, source channel}. The source stream is word bits [SW+CW-1:CW] and the source channel is word bits [CW-1:0].
- R2: Mode 10 selects constant delay. The output byte is the data-store byte at {~wr_bank, source stream, source channel}. The bank address bit is the MSB of dm_addr.
- R3: Mode 01 selects message output. The output byte equals bits [7:0] of the connection word.
- R4: Mode 11 selects test output. The byte comes from a 15-bit LFSR with feedback s[14]^s[13] and seed 15'h7FFF. Each byte takes 8 shifts {s[13:0],fb}, and the feedback bits fill the byte MSB first.
- R5: The LFSR advances only on strobed slots in mode 11. Other slots leave the test sequence where it stopped.
- R6: The connection store address equals {slot_stream, slot_chan}, which gives one location per output stream and channel.
- R7: slot_byte and slot_out_valid update one clock after a slot_valid strobe. Without a strobe, slot_byte holds its value and slot_out_valid is 0.
- R8: During reset, slot_byte is 0, slot_out_valid is 0 and the LFSR holds its seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_valid | input | 1 | Strobe: one output timeslot to be resolved |
| slot_stream | input | SW | Output stream counter |
| slot_chan | input | CW | Output channel counter |
| wr_bank | input | 1 | Data-store bank being written this frame |
| cm_addr | output | SW+CW | Connection store read address |
| cm_rdata | input | SW+CW+2 | Connection word: mode, source stream, source channel |
| dm_addr | output | SW+CW+1 | Data store read address: bank, stream, channel |
| dm_rdata | input | 8 | Data store read byte |
| slot_byte | output | 8 | Byte chosen for the timeslot |
| slot_out_valid | output | 1 | slot_byte was updated on this clock |

## Verification
The assertions assume that both stores answer in the same cycle as the address they are given. They also assume the connection word is a settled function of cm_addr, so the value sampled under a strobe is the value the mux used. The bench satisfies this by modelling both stores as arrays read through continuous assignments. It changes the counters, wr_bank and the store contents only at falling edges. Random slots use every mode, both banks and random gaps without a strobe. Directed cases cover the all-ones addresses and message bytes 00 and FF.

// File: rtl/slot_src_sel.sv
module slot_src_sel #(
  parameter int SW = 3,
  parameter int CW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_valid,
  input  logic [SW-1:0]     slot_stream,
  input  logic [CW-1:0]     slot_chan,
  input  logic              wr_bank,
  output logic [SW+CW-1:0]  cm_addr,
  input  logic [SW+CW+1:0]  cm_rdata,
  output logic [SW+CW:0]    dm_addr,
  input  logic [7:0]        dm_rdata,
  output logic [7:0]        slot_byte,
  output logic              slot_out_valid
);
  localparam int AW = SW + CW;
  localparam logic [14:0] SEED = 15'h7FFF;

  logic [1:0]  mode;
  logic [14:0] lfsr, lfsr_nxt;
  logic [7:0]  prbs_byte, pick;
  logic        test_slot;

  assign cm_addr   = {slot_stream, slot_chan};
  assign mode      = cm_rdata[AW+1:AW];
  assign dm_addr   = {wr_bank ^ mode[1], cm_rdata[AW-1:0]};
  assign test_slot = slot_valid && (mode == 2'b11);

  always_comb begin
    logic fb;
    lfsr_nxt = lfsr;
    prbs_byte = '0;
    for (int i = 0; i < 8; i++) begin
      fb = lfsr_nxt[14] ^ lfsr_nxt[13];
      prbs_byte[7-i] = fb;
      lfsr_nxt = {lfsr_nxt[13:0], fb};
    end
  end

  always_comb begin
    case (mode)
      2'b01:   pick = cm_rdata[7:0];
      2'b11:   pick = prbs_byte;
      default: pick = dm_rdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr <= SEED;
      slot_byte <= '0;
      slot_out_valid <= 1'b0;
    end else begin
      slot_out_valid <= slot_valid;
      if (slot_valid) slot_byte <= pick;
      if (test_slot)  lfsr <= lfsr_nxt;
    end
  end

  p_msg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && mode == 2'b01) |=> slot_byte == $past(cm_rdata[7:0]));

  p_switch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && !mode[0]) |=> slot_byte == $past(dm_rdata));

  p_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && mode == 2'b10) |-> dm_addr[AW] != wr_bank);

  p_prbs_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !test_slot |=> $stable(lfsr));

  p_lfsr_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_valid |=> ($stable(slot_byte) && !slot_out_valid));
endmodule

// File: tb/slot_src_sel_tb.sv
module slot_src_sel_tb_top;
  localparam int SW = 3, CW = 5, AW = SW + CW;

  logic clk = 0, rst_n = 0, slot_valid = 0, wr_bank = 0;
  logic [SW-1:0] slot_stream = '0;
  logic [CW-1:0] slot_chan = '0;
  logic [AW-1:0] cm_addr;
  logic [AW+1:0] cm_rdata;
  logic [AW:0]   dm_addr;
  logic [7:0]    dm_rdata, slot_byte;
  logic          slot_out_valid;

  logic [AW+1:0] cm_mem [0:(1<<AW)-1];
  logic [7:0]    dm_mem [0:(1<<(AW+1))-1];
  logic [14:0]   model_lfsr;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  assign cm_rdata = cm_mem[cm_addr];
  assign dm_rdata = dm_mem[dm_addr];

  slot_src_sel #(.SW(SW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid),
    .slot_stream(slot_stream), .slot_chan(slot_chan), .wr_bank(wr_bank),
    .cm_addr(cm_addr), .cm_rdata(cm_rdata), .dm_addr(dm_addr),
    .dm_rdata(dm_rdata), .slot_byte(slot_byte), .slot_out_valid(slot_out_valid));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] prbs_next(inout logic [14:0] s);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) begin
      logic f;
      f = s[14] ^ s[13];
      b[7-i] = f;
      s = {s[13:0], f};
    end
    return b;
  endfunction

  function automatic logic [7:0] expect_byte(input logic [AW+1:0] w, input logic bank);
    case (w[AW+1:AW])
      2'b00: return dm_mem[{bank, w[AW-1:0]}];
      2'b10: return dm_mem[{~bank, w[AW-1:0]}];
      2'b01: return w[7:0];
      default: return prbs_next(model_lfsr);
    endcase
  endfunction

  task automatic slot(input logic [SW-1:0] s, input logic [CW-1:0] c,
                      input logic bank, input logic [1:0] md, input logic [AW-1:0] src);
    logic [7:0] exp;
    string req;
    @(negedge clk);
    slot_stream = s; slot_chan = c; wr_bank = bank;
    cm_mem[{s, c}] = {md, src};
    slot_valid = 1;
    #1;
    check("R6 cm_addr", 16'(cm_addr), 16'({s, c}));
    exp = expect_byte({md, src}, bank);
    case (md)
      2'b00: req = "R1 variable";
      2'b10: req = "R2 constant";
      2'b01: req = "R3 message";
      default: req = "R4 prbs";
    endcase
    @(posedge clk); #1;
    check(req, 16'(slot_byte), 16'(exp));
    check("R7 valid", 16'(slot_out_valid), 16'd1);
    @(negedge clk);
    slot_valid = 0;
  endtask

  task automatic gap();
    logic [7:0] held;
    held = slot_byte;
    slot_stream = slot_stream + 1'b1;
    cm_mem[cm_addr] = {2'b11, AW'(8'h5A)};
    @(posedge clk); #1;
    check("R7 hold byte", 16'(slot_byte), 16'(held));
    check("R7 no valid", 16'(slot_out_valid), 16'd0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < (1<<AW); i++) cm_mem[i] = AW'(0) | (AW+2)'($urandom);
    for (int i = 0; i < (1<<(AW+1)); i++) dm_mem[i] = 8'($urandom);
    model_lfsr = 15'h7FFF;
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset byte", 16'(slot_byte), 16'd0);
    check("R8 reset valid", 16'(slot_out_valid), 16'd0);
    @(negedge clk); rst_n = 1;

    slot(3'd7, 5'd31, 1'b0, 2'b00, '1);
    slot(3'd7, 5'd31, 1'b1, 2'b00, '1);
    slot(3'd0, 5'd0, 1'b0, 2'b10, '1);
    slot(3'd0, 5'd0, 1'b1, 2'b10, '0);
    slot(3'd2, 5'd9, 1'b0, 2'b01, AW'(8'hFF));
    slot(3'd2, 5'd9, 1'b0, 2'b01, AW'(8'h00));
    slot(3'd1, 5'd1, 1'b0, 2'b11, '0);
    gap();
    slot(3'd4, 5'd2, 1'b1, 2'b01, AW'(8'h3C));
    slot(3'd1, 5'd1, 1'b0, 2'b11, '0); // R5 sequence resumes after non-test slots

    for (int n = 0; n < 400; n++) begin
      slot(SW'($urandom), CW'($urandom), 1'($urandom), 2'($urandom), AW'($urandom));
      if ($urandom_range(3) == 0) gap();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule